// File: doc/BRIEF.md
# Local Interrupt Acceptance and EOI Unit

This block is the per-processor end of interrupt delivery. It keeps three vectors of one bit per interrupt vector. The pending set records vectors that have been requested and not yet taken. The in-service set records vectors the core is handling. The level set records, for each vector, whether its most recent request was level-triggered. Requests arrive as messages that carry a vector, a source tag and a trigger kind. The unit always presents the highest pending vector to the core. When the core acknowledges, that vector moves from pending to in-service and a nesting counter goes up by one.

When the core writes end-of-interrupt, the unit retires the highest in-service vector, but only among vectors 32 and above. The lowest group of 32 is reserved and is never searched. If the retired vector was level-triggered, the unit sends a notice that carries the vector number back to the I/O interrupt router, so that the router can sample its input line again. That notice uses a valid/ready handshake. Further end-of-interrupt writes are refused until the current notice has been taken. An end-of-interrupt with nothing in service sets a sticky error flag.

Top module: `intr_service_unit`

## Requirements
- R1: After reset the pending, in-service and level sets are all zero, the depth is 0, `pend_valid`, `evt_valid` and `eoi_err` are 0, and `eoi_ready` is 1.
- R2: A request with `acc_valid` high sets the pending bit of `acc_vec` (any value 0 to 255) at the next clock edge. Requesting a vector that is already pending leaves it pending.
- R3: On each request, the level bit of `acc_vec` becomes `acc_level` when `acc_src` is 0 (I/O router) or 3 (auxiliary). It becomes 0 when `acc_src` is 1 (local timer) or 2 (inter-processor fixed), whatever `acc_level` is.
- R4: `pend_valid` is 1 exactly when some pending bit is set, and `pend_vec` is then the highest-numbered pending vector.
- R5: `ack_req` with `pend_valid` high clears the pending bit of `pend_vec`, sets its in-service bit and raises the depth by one at the next edge. `ack_req` with nothing pending changes nothing.
- R6: An accepted end-of-interrupt clears only the highest in-service bit among vectors 32 to 255 and lowers the depth by one. In-service bits 0 to 31 are never cleared this way. If no bit in 32 to 255 is set, nothing changes.
- R7: When the retired vector's level bit is set, `evt_valid` is 1 in the cycle after the end-of-interrupt, with `evt_vec` equal to that vector. When the level bit is clear, no notice is sent.
- R8: `evt_valid` and `evt_vec` hold until a cycle with `evt_ready` high, after which `evt_valid` drops. With `evt_ready` held at 1 the notice lasts exactly one cycle. `eoi_ready` is 0 while a notice is held, and an `eoi_req` in that time is ignored.
- R9: An end-of-interrupt accepted while the depth is 0 sets `eoi_err` and changes no other state. `eoi_err` stays set until reset.
- R10: In one cycle, a request and an acknowledge of the same vector leave its pending bit set and its in-service bit set. An acknowledge and an end-of-interrupt in the same cycle both take effect and leave the depth unchanged; a vector that is retired and acknowledged together stays in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request message present |
| acc_vec | input | 8 | Requested vector |
| acc_src | input | 2 | Source tag: 0 router, 1 timer, 2 inter-processor, 3 auxiliary |
| acc_level | input | 1 | 1 = level-triggered request |
| ack_req | input | 1 | Core acknowledges the presented vector |
| pend_valid | output | 1 | Some vector is pending |
| pend_vec | output | 8 | Highest pending vector |
| eoi_req | input | 1 | End-of-interrupt write |
| eoi_ready | output | 1 | End-of-interrupt can be accepted |
| evt_valid | output | 1 | Notice toward the I/O router is valid |
| evt_vec | output | 8 | Vector carried by the notice |
| evt_ready | input | 1 | I/O router takes the notice |
| depth | output | 9 | In-service nesting depth |
| eoi_err | output | 1 | Sticky end-of-interrupt-without-service flag |
| irr | output | 256 | Pending set |
| isr | output | 256 | In-service set |
| tmr | output | 256 | Level set |

## Verification
Several operations can land in the same cycle, and the bench forces these overlaps on purpose. In one case a request and an acknowledge target the same vector in one cycle. The bench then checks that the pending bit is set again while the in-service bit is also set. In another case an acknowledge and an end-of-interrupt fall in the same cycle and hit the same vector. Here the bench expects the in-service bit to stay set, the depth to stay unchanged and no notice, because that vector is edge-triggered. A further sweep moves every vector through request, acknowledge and retirement. At each step the bench computes the expected order, depth and notices from the vector number alone.

// File: rtl/isu_pkg.sv
package isu_pkg;

    typedef enum logic [1:0] {
        SRC_ROUTER = 2'd0,
        SRC_TIMER  = 2'd1,
        SRC_IPI    = 2'd2,
        SRC_AUX    = 2'd3
    } isu_src_e;

    // Local sources are always delivered edge-triggered.
    function automatic logic src_forces_edge(isu_src_e s);
        return (s == SRC_TIMER) || (s == SRC_IPI);
    endfunction

endpackage

// File: rtl/isu_hi_find.sv
// Highest set bit of a vector, searched group by group; groups below
// LO_GRP are excluded from the search.
module isu_hi_find #(
    parameter int W      = 256,
    parameter int GRP_W  = 32,
    parameter int LO_GRP = 0,
    localparam int IW    = $clog2(W),
    localparam int NG    = W / GRP_W,
    localparam int GB    = $clog2(GRP_W),
    localparam int GSW   = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [NG-1:0]         grp_any;
    logic [NG-1:0][GB-1:0] grp_idx;
    logic [GSW-1:0]        sel;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_any[g] = |vec[g*GRP_W +: GRP_W];
    end

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            grp_idx[g] = '0;
            for (int b = 0; b < GRP_W; b++) begin
                if (vec[g*GRP_W + b]) grp_idx[g] = GB'(b);
            end
        end
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int g = 0; g < NG; g++) begin
            if ((g >= LO_GRP) && grp_any[g]) begin
                found = 1'b1;
                sel   = GSW'(g);
            end
        end
        idx = IW'(int'(sel) * GRP_W + int'(grp_idx[sel]));
    end

endmodule

// File: rtl/isu_dec.sv
// Enabled one-hot decoder.
module isu_dec #(
    parameter int W  = 256,
    localparam int IW = $clog2(W)
) (
    input  logic          en,
    input  logic [IW-1:0] sel,
    output logic [W-1:0]  hot
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hot[i] = en && (sel == IW'(i));
    end

endmodule

// File: rtl/intr_service_unit.sv
module intr_service_unit
    import isu_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int GRP_W     = 32,
    parameter int RSVD_GRPS = 1,
    localparam int VEC_W    = $clog2(NUM_VEC),
    localparam int DEP_W    = $clog2(NUM_VEC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [VEC_W-1:0]   acc_vec,
    input  logic [1:0]         acc_src,
    input  logic               acc_level,
    input  logic               ack_req,
    output logic               pend_valid,
    output logic [VEC_W-1:0]   pend_vec,
    input  logic               eoi_req,
    output logic               eoi_ready,
    output logic               evt_valid,
    output logic [VEC_W-1:0]   evt_vec,
    input  logic               evt_ready,
    output logic [DEP_W-1:0]   depth,
    output logic               eoi_err,
    output logic [NUM_VEC-1:0] irr,
    output logic [NUM_VEC-1:0] isr,
    output logic [NUM_VEC-1:0] tmr
);

    localparam logic [DEP_W-1:0] DEP_MAX = '1;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [DEP_W-1:0]   depth;
        logic               evt_v;
        logic [VEC_W-1:0]   evt_vec;
        logic               err;
    } st_t;

    st_t st_d, st_q;

    logic               irr_found, isr_found;
    logic [VEC_W-1:0]   irr_idx, isr_idx;
    logic               acc_lvl, ack_fire, eoi_take, eoi_bad, eoi_fire;
    logic [NUM_VEC-1:0] acc_hot, ack_hot, eoi_hot;

    // Pending search covers every vector.
    isu_hi_find #(.W(NUM_VEC), .GRP_W(GRP_W), .LO_GRP(0)) u_find_irr (
        .vec   (st_q.irr),
        .found (irr_found),
        .idx   (irr_idx)
    );

    // Retirement search skips the reserved low groups.
    isu_hi_find #(.W(NUM_VEC), .GRP_W(GRP_W), .LO_GRP(RSVD_GRPS)) u_find_isr (
        .vec   (st_q.isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    isu_dec #(.W(NUM_VEC)) u_dec_acc (.en(acc_valid), .sel(acc_vec), .hot(acc_hot));
    isu_dec #(.W(NUM_VEC)) u_dec_ack (.en(ack_fire),  .sel(irr_idx), .hot(ack_hot));
    isu_dec #(.W(NUM_VEC)) u_dec_eoi (.en(eoi_fire),  .sel(isr_idx), .hot(eoi_hot));

    always_comb begin
        acc_lvl  = acc_level && !src_forces_edge(isu_src_e'(acc_src));
        ack_fire = ack_req && irr_found;
        eoi_take = eoi_req && !st_q.evt_v;
        eoi_bad  = eoi_take && (st_q.depth == '0);
        eoi_fire = eoi_take && (st_q.depth != '0) && isr_found;

        st_d = st_q;

        // Acknowledge clears first, a new request sets afterwards.
        st_d.irr = (st_q.irr & ~ack_hot) | acc_hot;
        st_d.tmr = acc_lvl ? (st_q.tmr | acc_hot) : (st_q.tmr & ~acc_hot);
        // Retirement clears first, acknowledge sets afterwards.
        st_d.isr = (st_q.isr & ~eoi_hot) | ack_hot;

        unique case ({ack_fire, eoi_fire})
            2'b10:   st_d.depth = (st_q.depth == DEP_MAX) ? st_q.depth
                                                           : st_q.depth + DEP_W'(1);
            2'b01:   st_d.depth = st_q.depth - DEP_W'(1);
            default: st_d.depth = st_q.depth;
        endcase

        if (st_q.evt_v && evt_ready) st_d.evt_v = 1'b0;
        if (eoi_fire && st_q.tmr[isr_idx]) begin
            st_d.evt_v   = 1'b1;
            st_d.evt_vec = isr_idx;
        end

        if (eoi_bad) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_valid = irr_found;
    assign pend_vec   = irr_idx;
    assign eoi_ready  = !st_q.evt_v;
    assign evt_valid  = st_q.evt_v;
    assign evt_vec    = st_q.evt_vec;
    assign depth      = st_q.depth;
    assign eoi_err    = st_q.err;
    assign irr        = st_q.irr;
    assign isr        = st_q.isr;
    assign tmr        = st_q.tmr;

endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
    parameter int NUM_VEC = 256,
    parameter int GRP_W   = 32,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int DEP_W  = $clog2(NUM_VEC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_req,
    input logic               pend_valid,
    input logic [VEC_W-1:0]   pend_vec,
    input logic               eoi_req,
    input logic               eoi_ready,
    input logic               evt_valid,
    input logic [VEC_W-1:0]   evt_vec,
    input logic               evt_ready,
    input logic [DEP_W-1:0]   depth,
    input logic               eoi_err,
    input logic [NUM_VEC-1:0] irr,
    input logic [NUM_VEC-1:0] isr
);

    a_r4_pend_matches_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid ? irr[pend_vec] : (irr == '0)));

    a_r5_depth_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (depth == $past(depth)) || (depth == $past(depth) + DEP_W'(1))
                 || (depth == $past(depth) - DEP_W'(1)));

    a_r6_low_group_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req) |=> (isr[GRP_W-1:0] == $past(isr[GRP_W-1:0])));

    a_r7_notice_from_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_valid) |-> $past(eoi_req));

    a_r8_notice_held: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_vec)));

    a_r9_empty_eoi_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && eoi_ready && (depth == '0) && !ack_req) |=> (eoi_err && $stable(isr)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |=> eoi_err);

endmodule

bind intr_service_unit isu_checker #(.NUM_VEC(NUM_VEC), .GRP_W(GRP_W)) u_isu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .pend_valid (pend_valid),
    .pend_vec   (pend_vec),
    .eoi_req    (eoi_req),
    .eoi_ready  (eoi_ready),
    .evt_valid  (evt_valid),
    .evt_vec    (evt_vec),
    .evt_ready  (evt_ready),
    .depth      (depth),
    .eoi_err    (eoi_err),
    .irr        (irr),
    .isr        (isr)
);

// File: tb/tb_intr_service_unit.sv
module tb_intr_service_unit;

    localparam int CLK_P = 10;
    localparam int NV    = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_valid, acc_level, ack_req, eoi_req, evt_ready;
    logic [7:0]    acc_vec;
    logic [1:0]    acc_src;
    logic          pend_valid, eoi_ready, evt_valid, eoi_err;
    logic [7:0]    pend_vec, evt_vec;
    logic [8:0]    depth;
    logic [NV-1:0] irr, isr, tmr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    intr_service_unit dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_src(acc_src), .acc_level(acc_level),
        .ack_req(ack_req), .pend_valid(pend_valid), .pend_vec(pend_vec),
        .eoi_req(eoi_req), .eoi_ready(eoi_ready),
        .evt_valid(evt_valid), .evt_vec(evt_vec), .evt_ready(evt_ready),
        .depth(depth), .eoi_err(eoi_err), .irr(irr), .isr(isr), .tmr(tmr)
    );

    function automatic bit lvl_of(int v);
        return (v % 3) == 0;
    endfunction

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic chk(input string tag, input logic [NV-1:0] act, input logic [NV-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; acc_valid = 0; acc_vec = 0; acc_src = 0; acc_level = 0;
        ack_req = 0; eoi_req = 0; evt_ready = 1;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic accept(input int v, input int src, input bit lv);
        acc_valid = 1; acc_vec = 8'(v); acc_src = 2'(src); acc_level = lv;
        tick();
        acc_valid = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NV-1:0] exp_tmr;
        logic [NV-1:0] exp_isr;
        int n_bad;

        do_reset();
        // R1 reset state
        chk("R1 irr", irr, '0);
        chk("R1 isr", isr, '0);
        chk("R1 tmr", tmr, '0);
        chk("R1 depth", NV'(depth), '0);
        chk("R1 flags", NV'({pend_valid, evt_valid, eoi_err, eoi_ready}), NV'(4'b0001));

        // R2/R3: request every vector through the router with a computed trigger kind
        exp_tmr = '0;
        for (int v = 0; v < NV; v++) begin
            accept(v, 0, lvl_of(v));
            exp_tmr[v] = lvl_of(v);
        end
        chk("R2 all pending", irr, '1);
        chk("R3 router level set", tmr, exp_tmr);
        accept(77, 0, lvl_of(77));
        chk("R2 repeat request keeps set", irr, '1);

        // R3 local sources forced to edge, auxiliary honours level
        accept(201, 1, 1'b1);
        chk("R3 timer forced edge", NV'(tmr[201]), NV'(0));
        accept(202, 2, 1'b1);
        chk("R3 ipi forced edge", NV'(tmr[202]), NV'(0));
        accept(203, 3, 1'b1);
        chk("R3 aux keeps level", NV'(tmr[203]), NV'(1));
        accept(201, 0, lvl_of(201));
        accept(202, 0, lvl_of(202));
        accept(203, 0, lvl_of(203));
        chk("R3 restored", tmr, exp_tmr);

        // R4/R5 acknowledge everything, highest first
        n_bad = 0;
        for (int k = 0; k < NV; k++) begin
            n_run++;
            if (!pend_valid || pend_vec != 8'(255 - k)) begin
                n_fail++; n_bad++;
                $display("FAIL R4 pending order: actual %0d/%0d expected 1/%0d",
                         pend_valid, pend_vec, 255 - k);
            end
            ack_req = 1; tick(); ack_req = 0;
        end
        chk("R5 irr empty", irr, '0);
        chk("R5 isr full", isr, '1);
        chk("R5 depth 256", NV'(depth), NV'(256));
        chk("R4 nothing pending", NV'(pend_valid), NV'(0));
        ack_req = 1; tick(); ack_req = 0;
        chk("R5 empty ack depth", NV'(depth), NV'(256));
        chk("R5 empty ack isr", isr, '1);

        // R6/R7/R8 retire 255 down to 32
        evt_ready = 1;
        for (int v = 255; v >= 32; v--) begin
            eoi_req = 1; tick(); eoi_req = 0;
            exp_isr = (NV'(1) << v) - NV'(1);
            chk("R6 retire highest", isr, exp_isr);
            chk("R6 depth down", NV'(depth), NV'(v));
            chk("R7 notice valid", NV'(evt_valid), NV'(lvl_of(v)));
            if (lvl_of(v)) chk("R7 notice vector", NV'(evt_vec), NV'(v));
            tick();
            chk("R8 one-cycle notice", NV'(evt_valid), NV'(0));
        end
        eoi_req = 1; tick(); eoi_req = 0;
        chk("R6 low group untouched", isr, NV'(32'hFFFF_FFFF));
        chk("R6 depth kept", NV'(depth), NV'(32));
        chk("R6 no notice", NV'(evt_valid), NV'(0));

        // R8 handshake back-pressure
        do_reset();
        accept(100, 0, 1'b1);
        accept(90, 0, 1'b1);
        ack_req = 1; tick(); tick(); ack_req = 0;
        chk("R5 two in service", NV'(depth), NV'(2));
        evt_ready = 0;
        eoi_req = 1; tick();
        chk("R7 notice 100", NV'({evt_valid, evt_vec}), NV'({1'b1, 8'd100}));
        chk("R8 not ready", NV'(eoi_ready), NV'(0));
        tick(); eoi_req = 0;
        chk("R8 refused eoi isr", NV'(isr[90]), NV'(1));
        chk("R8 refused eoi depth", NV'(depth), NV'(1));
        chk("R8 notice held", NV'({evt_valid, evt_vec}), NV'({1'b1, 8'd100}));
        evt_ready = 1; tick();
        chk("R8 taken", NV'(evt_valid), NV'(0));
        eoi_req = 1; tick(); eoi_req = 0;
        chk("R7 notice 90", NV'({evt_valid, evt_vec}), NV'({1'b1, 8'd90}));
        chk("R6 depth zero", NV'(depth), NV'(0));
        tick();

        // R9 empty end-of-interrupt
        eoi_req = 1; tick(); eoi_req = 0;
        chk("R9 err set", NV'(eoi_err), NV'(1));
        chk("R9 state kept", isr, '0);
        chk("R9 depth kept", NV'(depth), NV'(0));
        tick(); tick(); tick();
        chk("R9 err sticky", NV'(eoi_err), NV'(1));

        // R10 same-cycle overlaps
        accept(50, 0, 1'b0);
        acc_valid = 1; acc_vec = 8'd50; acc_src = 0; acc_level = 0; ack_req = 1;
        tick();
        acc_valid = 0; ack_req = 0;
        chk("R10 request+ack irr", NV'(irr[50]), NV'(1));
        chk("R10 request+ack isr", NV'(isr[50]), NV'(1));
        chk("R10 request+ack depth", NV'(depth), NV'(1));
        ack_req = 1; eoi_req = 1; tick(); ack_req = 0; eoi_req = 0;
        chk("R10 ack+eoi isr", isr, NV'(1) << 50);
        chk("R10 ack+eoi irr", irr, '0);
        chk("R10 ack+eoi depth", NV'(depth), NV'(1));
        chk("R10 ack+eoi no notice", NV'(evt_valid), NV'(0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule